// File: doc/BRIEF.md
# Unaligned Burst Write Strobe Generator

This block walks an incrementing write burst one beat at a time and produces, for each beat, the byte address, the byte-lane write strobe for a data bus of `DATA_BYTES` lanes and a flag marking the final beat. A burst is described by a start address, a size code (bytes per beat = 2^size) and a length code (beats = length + 1). It is handed to the block through a valid/ready command port. The block then presents beats on a valid/ready beat port. The beat-ready input stands for the write-data handshake of the bus.

Only the first beat can be unaligned. Its strobe covers the lanes from the start address up to the next size boundary. Every later beat sits on a size boundary and enables all 2^size lanes at lane offset (address mod `DATA_BYTES`). The bytes lost at the start of the burst are not made up: no extra beat is added, and the last beat is never a partial one.

Back-pressure rules: a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while no burst is in progress, so commands offered during a burst are ignored. A beat advances on a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, the presented beat holds all of its fields.

Top module: `burst_strobe_gen`

## Requirements
- R1: After reset `cmd_ready` is 1, and `beat_valid`, `beat_last` and `beat_strb` are 0.
- R2: A command is accepted only when `cmd_ready` is 1. A `cmd_valid` pulse during a burst has no effect on the beats of that burst, and `cmd_ready` stays 0 until the burst ends.
- R3: The first beat's address equals the start address. Its strobe sets lanes lo..hi-1, where lo = addr mod DATA_BYTES and hi = (addr rounded down to a 2^size multiple) mod DATA_BYTES + 2^size. Bit i of `beat_strb` is lane i.
- R4: Each later beat's address is the previous beat address rounded down to a multiple of 2^size, plus 2^size. Its strobe sets exactly the 2^size lanes starting at lane (address mod DATA_BYTES).
- R5: A burst presents exactly length+1 beats. `beat_last` is 1 only on the final one.
- R6: While `beat_valid` is 1 and `beat_ready` is 0, `beat_addr`, `beat_strb` and `beat_last` hold their values and `beat_valid` stays 1.
- R7: The cycle after the handshake of the last beat, `beat_valid` is 0 and `cmd_ready` is 1.
- R8: The total number of strobe bits set over a burst is (length+1)*2^size minus (start address mod 2^size).
- R9: `beat_strb` is all zero whenever `beat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Block idle, command will be taken |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_size | input | SIZE_W | Size code, 2^size bytes per beat |
| cmd_len | input | LEN_W | Length code, beats minus one |
| beat_valid | output | 1 | A beat is presented |
| beat_ready | input | 1 | Write-data handshake for the current beat |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_strb | output | DATA_BYTES | Byte-lane enables of the current beat |
| beat_last | output | 1 | Current beat is the final beat |

## Verification
The assertions take for granted that the size code never exceeds log2(DATA_BYTES), so one beat always fits on the bus. They also take for granted that the start address plus the burst span does not wrap the address width. The bench only issues size codes from 0 to log2(DATA_BYTES) and keeps start addresses small against a 16-bit address. It sweeps every start offset within two bus words, every legal size and lengths 0 to 5. Stalls of varying length are applied to each burst, and a competing command is offered mid-burst.

// File: rtl/bsg_pkg.sv
package bsg_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } run_state_t;

  // lane enable test: lane inside the half-open window [lo, hi)
  function automatic logic lane_in_window(input int lane, input int lo, input int hi);
    return (lane >= lo) && (lane < hi);
  endfunction

endpackage

// File: rtl/bsg_beat_ctrl.sv
module bsg_beat_ctrl
  import bsg_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              beat_ready,
  output logic              busy,
  output logic              load,
  output logic              advance,
  output logic              last,
  output logic [SIZE_W-1:0] size_q
);

  run_state_t       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;

  assign busy    = (state_q == ST_RUN);
  assign load    = cmd_valid && !busy;
  assign last    = busy && (cnt_q == len_q);
  assign advance = busy && beat_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      size_q  <= '0;
    end else if (load) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      len_q   <= cmd_len;
      size_q  <= cmd_size;
    end else if (advance) begin
      if (last) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= len_q)); // R5

  AST_BUSY_CMD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> ($stable(len_q) && $stable(size_q))); // R2

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && last) |=> !busy); // R7

endmodule

// File: rtl/bsg_addr_step.sv
module bsg_addr_step #(
  parameter int ADDR_W = 16,
  parameter int SIZE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic              last,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] size_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] next_addr;

  assign step      = ADDR_W'(1) << size_q;
  assign low_mask  = step - ADDR_W'(1);
  assign next_addr = (addr_q & ~low_mask) + step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= cmd_addr;
    end else if (advance && !last) begin
      addr_q <= next_addr;
    end
  end

  AST_STEP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !last) |=> (((addr_q & low_mask) == '0)
                            && (addr_q > $past(addr_q))
                            && ((addr_q - $past(addr_q)) <= step))); // R4

endmodule

// File: rtl/bsg_lane_mask.sv
module bsg_lane_mask
  import bsg_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int SIZE_W     = 3,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [SIZE_W-1:0]     size_q,
  output logic [DATA_BYTES-1:0] strb
);

  localparam int LANE_W = $clog2(DATA_BYTES);

  logic [LANE_W:0] nbytes;
  logic [LANE_W:0] off;
  logic [LANE_W:0] lo;
  logic [LANE_W:0] hi;

  assign nbytes = (LANE_W+1)'(1) << size_q;
  assign off    = {1'b0, addr[LANE_W-1:0]};
  assign lo     = off;
  assign hi     = (off & ~(nbytes - (LANE_W+1)'(1))) + nbytes;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    assign strb[g] = en && lane_in_window(g, int'(lo), int'(hi));
  end

  AST_IDLE_NO_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (strb == '0)); // R9

  AST_STRB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> ($countones(strb) == int'(nbytes) - int'(addr & ((ADDR_W'(1) << size_q) - ADDR_W'(1))))); // R3

endmodule

// File: rtl/burst_strobe_gen.sv
module burst_strobe_gen #(
  parameter int ADDR_W     = 16,
  parameter int DATA_BYTES = 4,
  parameter int LEN_W      = 8,
  parameter int SIZE_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [SIZE_W-1:0]     cmd_size,
  input  logic [LEN_W-1:0]      cmd_len,
  output logic                  beat_valid,
  input  logic                  beat_ready,
  output logic [ADDR_W-1:0]     beat_addr,
  output logic [DATA_BYTES-1:0] beat_strb,
  output logic                  beat_last
);

  logic              busy;
  logic              load;
  logic              advance;
  logic              last;
  logic [SIZE_W-1:0] size_q;

  bsg_beat_ctrl #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_len(cmd_len),
    .cmd_size(cmd_size), .beat_ready(beat_ready), .busy(busy), .load(load),
    .advance(advance), .last(last), .size_q(size_q)
  );

  bsg_addr_step #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance), .last(last),
    .cmd_addr(cmd_addr), .size_q(size_q), .addr_q(beat_addr)
  );

  bsg_lane_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_BYTES(DATA_BYTES)) u_mask (
    .clk(clk), .rst_n(rst_n), .en(busy), .addr(beat_addr), .size_q(size_q),
    .strb(beat_strb)
  );

  assign cmd_ready  = !busy;
  assign beat_valid = busy;
  assign beat_last  = last;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> (beat_valid && $stable(beat_addr)
                                     && $stable(beat_strb) && $stable(beat_last))); // R6

  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && beat_ready && beat_last) |=> (cmd_ready && !beat_valid)); // R7

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !(beat_ready && beat_last)) |=> !cmd_ready); // R2

endmodule

// File: tb/sim_burst_strobe_gen.sv
module sim_burst_strobe_gen;
  localparam int AW = 16;
  localparam int DB = 4;
  localparam int LW = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [SW-1:0] cmd_size = '0;
  logic [LW-1:0] cmd_len = '0;
  logic beat_valid;
  logic beat_ready = 1'b0;
  logic [AW-1:0] beat_addr;
  logic [DB-1:0] beat_strb;
  logic beat_last;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_strobe_gen #(.ADDR_W(AW), .DATA_BYTES(DB), .LEN_W(LW), .SIZE_W(SW)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_len(cmd_len),
    .beat_valid(beat_valid), .beat_ready(beat_ready), .beat_addr(beat_addr),
    .beat_strb(beat_strb), .beat_last(beat_last)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_burst(input int a, input int sz, input int ln, input int stall_seed);
    int nb;
    int tot;
    int cur;
    nb  = 1 << sz;
    tot = 0;
    cur = a;
    @(negedge clk);
    chk("R2 ready when idle", cmd_ready, 1);
    cmd_addr  = AW'(a);
    cmd_size  = SW'(sz);
    cmd_len   = LW'(ln);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int k = 0; k <= ln; k++) begin
      int lo;
      int cnt;
      int exp_strb;
      int stalls;
      lo       = cur % DB;
      cnt      = nb - (cur % nb);
      exp_strb = ((1 << cnt) - 1) << lo;
      stalls   = (stall_seed + k) % 3;
      for (int s = 0; s < stalls; s++) begin
        beat_ready = 1'b0;
        if (k == 0 && s == 0) begin
          cmd_addr  = AW'(a + 100);
          cmd_len   = LW'(ln + 3);
          cmd_valid = 1'b1;
        end
        chk("R2 not ready while busy", cmd_ready, 0);
        chk("R6 valid during stall", beat_valid, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R6 addr held", beat_addr, cur);
        chk("R6 strb held", beat_strb, exp_strb);
      end
      if (k == 0) chk("R3 first addr", beat_addr, a);
      else        chk("R4 later addr", beat_addr, cur);
      if (k == 0) chk("R3 first strb", beat_strb, exp_strb);
      else        chk("R4 later strb", beat_strb, exp_strb);
      chk("R5 last flag", beat_last, (k == ln) ? 1 : 0);
      chk("R5 valid", beat_valid, 1);
      tot += $countones(beat_strb);
      beat_ready = 1'b1;
      @(negedge clk);
      beat_ready = 1'b0;
      cur = (cur / nb) * nb + nb;
    end
    chk("R8 total bytes", tot, (ln + 1) * nb - (a % nb));
    chk("R7 valid low after last", beat_valid, 0);
    chk("R7 ready after last", cmd_ready, 1);
    chk("R9 strb zero when idle", beat_strb, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 valid", beat_valid, 0);
    chk("R1 last", beat_last, 0);
    chk("R1 strb", beat_strb, 0);
    rst_n = 1'b1;
    // the two worked cases: 5 beats of 4 bytes at 0x01, 5 beats of 2 bytes at 0x03
    run_burst(1, 2, 4, 0);
    run_burst(3, 1, 4, 1);
    for (int sz = 0; sz <= $clog2(DB); sz++)
      for (int a = 0; a < 2 * DB; a++)
        for (int ln = 0; ln <= 5; ln++)
          run_burst(a + 32, sz, ln, a + ln + sz);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule